// File: doc/BRIEF.md
# Accelerometer SPI Polling Master

This block is a host-side SPI controller that talks to a two-axis accelerometer slave. It reads the X acceleration channel, the Y acceleration channel and the temperature register in turn. It builds the serial clock from the system clock through a divider. It drives chip select and the outgoing data line, and it captures the slave's reply. Each finished frame appears on a result port as a one-cycle valid pulse, a channel tag and an 11-bit data field.

The sequence always starts with X. Two enable inputs add Y and temperature to the rotation. A frame begins on a single start request or, while auto-poll is held, back to back. Between frames, chip select stays high for a long minimum gap that the slave needs to reload its data registers. This gap also applies before the first frame after reset.

Every timing value is a parameter counted in system clock cycles: the half period of the serial clock and the chip-select-high gap.

Top module: `accel_poll_master`

## Requirements
- R1: During and directly after reset, `spi_csb_n` is high, `spi_sck` is low, `spi_mosi` is low and `res_valid` is low.
- R2: While chip select is low, every phase lasts exactly HALF_DIV system cycles. This covers the lead from chip select falling to the first SCK rise, each SCK high phase, each SCK low phase, and the tail from the last SCK fall to chip select rising. SCK is low whenever chip select is high.
- R3: The command byte goes out MSB first: 0x10 for X, 0x11 for Y and 0x08 for temperature. After the command, MOSI is zero. MOSI changes only while SCK is low, and it is low whenever chip select is high.
- R4: A frame has 19 SCK rising edges for X or Y and 16 for temperature.
- R5: MISO is sampled on the SCK rising edges that follow the 8 command bits, MSB first. X and Y return 11 bits. Temperature returns 8 bits, zero-extended in `res_data` (bits 10:8 are zero).
- R6: `res_valid` is a one-cycle pulse. It is asserted in the same cycle in which `spi_csb_n` returns high. `res_chan` carries 0 for X, 1 for Y and 2 for temperature, and is never 3.
- R7: Chip select stays high for at least GAP_CYC cycles before every frame. This includes the first frame, which is counted from the release of reset.
- R8: The order is X, then Y if `inc_y` is set, then temperature if `inc_t` is set, then back to X. If the channel next in turn is disabled when a frame begins, X is read instead.
- R9: A frame begins only when `start` or `auto_poll` is high. A `start` pulse that arrives during a frame or during the gap is ignored and produces no frame.
- R10: With `auto_poll` held, chip select falls exactly GAP_CYC cycles after it last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame when ready |
| auto_poll | input | 1 | Poll continuously while high |
| inc_y | input | 1 | Include the Y channel in the rotation |
| inc_t | input | 1 | Include the temperature register in the rotation |
| spi_sck | output | 1 | Serial clock to the slave |
| spi_csb_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Command and data to the slave |
| spi_miso | input | 1 | Reply from the slave |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 2 | Channel tag of the result |
| res_data | output | 11 | Result data, zero-extended |

## Verification
The bench attacks the response window. If a design sampled on the wrong edge or started one bit early, the reply would be shifted by one position, and the fixed pattern 975 plus all-ones and all-zeros words expose that at once. The temperature frame is three bits shorter. A design that kept the 11-bit length would show extra rising edges and misaligned data.

A start pulse placed in the middle of a frame and another placed inside the gap would, in a design that latches requests, produce an extra frame. The first frame after reset and back-to-back auto-poll frames are timed to the cycle, which exposes an off-by-one gap counter. Toggling the channel enables with the rotation parked on a disabled channel shows whether the design falls back to X.

// File: rtl/accel_poll_pkg.sv
package accel_poll_pkg;

  localparam int CMD_BITS = 8;
  localparam int ACC_BITS = 11;
  localparam int TMP_BITS = 8;
  localparam int BIT_W    = $clog2(CMD_BITS + ACC_BITS + 1);

  typedef enum logic [1:0] {
    CH_X = 2'd0,
    CH_Y = 2'd1,
    CH_T = 2'd2
  } chan_e;

  function automatic logic [CMD_BITS-1:0] chan_cmd(chan_e c);
    case (c)
      CH_Y:    return 8'h11;
      CH_T:    return 8'h08;
      default: return 8'h10;
    endcase
  endfunction

  function automatic logic [BIT_W-1:0] chan_len(chan_e c);
    if (c == CH_T) return BIT_W'(CMD_BITS + TMP_BITS);
    return BIT_W'(CMD_BITS + ACC_BITS);
  endfunction

endpackage

// File: rtl/poll_sequencer.sv
module poll_sequencer
  import accel_poll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  inc_y,
  input  logic  inc_t,
  output chan_e cur_chan
);

  chan_e pos_q, pos_d;

  // a parked position whose channel was disabled falls back to X
  always_comb begin
    cur_chan = pos_q;
    if ((pos_q == CH_Y && !inc_y) || (pos_q == CH_T && !inc_t))
      cur_chan = CH_X;
  end

  always_comb begin
    pos_d = pos_q;
    if (advance) begin
      case (cur_chan)
        CH_X:    pos_d = inc_y ? CH_Y : (inc_t ? CH_T : CH_X);
        CH_Y:    pos_d = inc_t ? CH_T : CH_X;
        default: pos_d = CH_X;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= CH_X;
    else        pos_q <= pos_d;
  end

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic ready
);

  localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)           cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import accel_poll_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  chan_e               chan_in,
  input  logic                miso,
  output logic                sck,
  output logic                csb_n,
  output logic                mosi,
  output logic                idle,
  output logic                done,
  output chan_e               done_chan,
  output logic [ACC_BITS-1:0] done_data
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] HLOAD = HW'(HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL} st_e;

  st_e                 st_q, st_d;
  logic [HW-1:0]       hc_q, hc_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [BIT_W-1:0]    len_q, len_d;
  logic [CMD_BITS-1:0] tx_q, tx_d;
  logic [ACC_BITS-1:0] rx_q, rx_d;
  chan_e               ch_q, ch_d;
  logic                sck_q, sck_d, csb_q, csb_d, mosi_q, mosi_d, done_q, done_d;
  logic [ACC_BITS-1:0] dat_q, dat_d;
  logic [CMD_BITS-1:0] cmd;

  assign cmd = chan_cmd(chan_in);

  always_comb begin
    st_d = st_q;   hc_d = hc_q;   bit_d = bit_q; len_d = len_q;
    tx_d = tx_q;   rx_d = rx_q;   ch_d = ch_q;
    sck_d = sck_q; csb_d = csb_q; mosi_d = mosi_q;
    done_d = 1'b0; dat_d = dat_q;
    case (st_q)
      S_IDLE: if (go) begin
        st_d   = S_LOW;
        hc_d   = HLOAD;
        csb_d  = 1'b0;
        mosi_d = cmd[CMD_BITS-1];
        tx_d   = {cmd[CMD_BITS-2:0], 1'b0};
        bit_d  = '0;
        len_d  = chan_len(chan_in);
        ch_d   = chan_in;
        rx_d   = '0;
      end
      S_LOW: begin
        if (hc_q == '0) begin
          st_d  = S_HIGH;
          hc_d  = HLOAD;
          sck_d = 1'b1;
          if (bit_q >= BIT_W'(CMD_BITS)) rx_d = {rx_q[ACC_BITS-2:0], miso};
        end else hc_d = hc_q - 1'b1;
      end
      S_HIGH: begin
        if (hc_q == '0) begin
          hc_d  = HLOAD;
          sck_d = 1'b0;
          if (bit_q == len_q - 1'b1) begin
            st_d   = S_TAIL;
            mosi_d = 1'b0;
          end else begin
            st_d   = S_LOW;
            bit_d  = bit_q + 1'b1;
            mosi_d = tx_q[CMD_BITS-1];
            tx_d   = {tx_q[CMD_BITS-2:0], 1'b0};
          end
        end else hc_d = hc_q - 1'b1;
      end
      default: begin
        if (hc_q == '0) begin
          st_d   = S_IDLE;
          csb_d  = 1'b1;
          done_d = 1'b1;
          dat_d  = rx_q;
        end else hc_d = hc_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; hc_q <= '0; bit_q <= '0; len_q <= '0;
      tx_q <= '0; rx_q <= '0; ch_q <= CH_X;
      sck_q <= 1'b0; csb_q <= 1'b1; mosi_q <= 1'b0;
      done_q <= 1'b0; dat_q <= '0;
    end else begin
      st_q <= st_d; hc_q <= hc_d; bit_q <= bit_d; len_q <= len_d;
      tx_q <= tx_d; rx_q <= rx_d; ch_q <= ch_d;
      sck_q <= sck_d; csb_q <= csb_d; mosi_q <= mosi_d;
      done_q <= done_d; dat_q <= dat_d;
    end
  end

  assign sck       = sck_q;
  assign csb_n     = csb_q;
  assign mosi      = mosi_q;
  assign idle      = (st_q == S_IDLE);
  assign done      = done_q;
  assign done_chan = ch_q;
  assign done_data = dat_q;

endmodule

// File: rtl/accel_poll_master.sv
module accel_poll_master
  import accel_poll_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC  = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        auto_poll,
  input  logic        inc_y,
  input  logic        inc_t,
  output logic        spi_sck,
  output logic        spi_csb_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        res_valid,
  output logic [1:0]  res_chan,
  output logic [10:0] res_data
);

  logic  eng_idle, gap_ready, go, finish;
  chan_e cur_chan, fin_chan;

  assign go = eng_idle && gap_ready && (start || auto_poll);

  poll_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .advance(go),
    .inc_y(inc_y), .inc_t(inc_t), .cur_chan(cur_chan)
  );

  gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .reload(finish), .ready(gap_ready)
  );

  // finish is the cycle before chip select rises; the gap counts from the rise
  assign finish = !spi_csb_n && (u_eng.st_q == u_eng.S_TAIL) && (u_eng.hc_q == '0);

  spi_frame_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .chan_in(cur_chan), .miso(spi_miso),
    .sck(spi_sck), .csb_n(spi_csb_n), .mosi(spi_mosi), .idle(eng_idle),
    .done(res_valid), .done_chan(fin_chan), .done_data(res_data)
  );

  assign res_chan = fin_chan;

endmodule

// File: rtl/accel_poll_checker.sv
module accel_poll_checker #(
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC  = 300
) (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_sck,
  input logic        spi_csb_n,
  input logic        spi_mosi,
  input logic        res_valid,
  input logic [1:0]  res_chan,
  input logic [10:0] res_data
);

  logic        sck_q;
  logic [31:0] run_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      run_q <= 32'(HALF_DIV);
      hi_q  <= '0;
    end else begin
      sck_q <= spi_sck;
      if (spi_sck != sck_q)  run_q <= 32'd1;
      else if (run_q < 32'(HALF_DIV)) run_q <= run_q + 1;
      if (!spi_csb_n)        hi_q <= '0;
      else if (hi_q < 32'(GAP_CYC)) hi_q <= hi_q + 1;
    end
  end

  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csb_n |-> !spi_sck);
  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck != sck_q) |-> (run_q >= 32'(HALF_DIV - 1)));
  p_mosi_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csb_n |-> !spi_mosi);
  p_temp_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_chan == 2'd2) |-> (res_data[10:8] == 3'd0));
  p_valid_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(spi_csb_n));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_tag_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_chan != 2'd3));
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csb_n) |-> (hi_q >= 32'(GAP_CYC)));

endmodule

bind accel_poll_master accel_poll_checker #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csb_n(spi_csb_n),
  .spi_mosi(spi_mosi), .res_valid(res_valid), .res_chan(res_chan),
  .res_data(res_data)
);

// File: tb/sim_accel_poll_master.sv
module sim_accel_poll_master;

  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int GAP   = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, auto_poll = 1'b0, inc_y = 1'b0, inc_t = 1'b0;
  logic spi_sck, spi_csb_n, spi_mosi, spi_miso = 1'b0;
  logic res_valid;
  logic [1:0]  res_chan;
  logic [10:0] res_data;

  accel_poll_master #(.HALF_DIV(HALF), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_poll(auto_poll),
    .inc_y(inc_y), .inc_t(inc_t), .spi_sck(spi_sck), .spi_csb_n(spi_csb_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0]  s_cmd;
  int          s_rise;
  logic [10:0] s_resp;
  bit          s_tail_bad;
  bit          force_en = 1'b0;
  logic [10:0] force_val = '0;

  always @(negedge spi_csb_n) begin
    s_rise = 0; s_cmd = '0; s_tail_bad = 1'b0;
    s_resp = force_en ? force_val : 11'($urandom);
  end
  always @(posedge spi_sck) if (!spi_csb_n) begin
    if (s_rise < 8) s_cmd = {s_cmd[6:0], spi_mosi};
    else if (spi_mosi) s_tail_bad = 1'b1;
    s_rise++;
  end
  always @(negedge spi_sck) if (!spi_csb_n && s_rise >= 8) begin
    if (s_cmd == 8'h08) spi_miso = s_resp[7 - (s_rise - 8)];
    else                spi_miso = s_resp[10 - (s_rise - 8)];
  end

  // ---------------- monitor ----------------
  int  cyc = 0, last_rise = 0, nframes = 0, exp_pos = 0, run = 0;
  bit  exact_gap = 1'b0, tbad = 1'b0, sck_p = 1'b0, csb_p = 1'b1, mosi_p = 1'b0;
  logic [10:0] last_data;

  function automatic logic [7:0] exp_cmd(int c);
    return (c == 1) ? 8'h11 : (c == 2) ? 8'h08 : 8'h10;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_sck != sck_p || spi_csb_n != csb_p) begin
        if (!csb_p && run != HALF) tbad = 1'b1;
        run = 1;
      end else run++;
      if (spi_mosi != mosi_p && spi_sck) tbad = 1'b1;
      if (!spi_csb_n && csb_p) begin
        if (exact_gap) check(cyc - last_rise == GAP, "R10 auto gap", cyc - last_rise, GAP);
        else           check(cyc - last_rise >= GAP, "R7 min gap", cyc - last_rise, GAP);
        tbad = 1'b0;
      end
      if (spi_csb_n && !csb_p) last_rise = cyc;
      if (res_valid) begin
        int eff, exp_len;
        logic [10:0] exp_d;
        eff = ((exp_pos == 1 && !inc_y) || (exp_pos == 2 && !inc_t)) ? 0 : exp_pos;
        exp_len = (eff == 2) ? 16 : 19;
        exp_d   = (eff == 2) ? {3'b0, s_resp[7:0]} : s_resp;
        check(spi_csb_n && !csb_p, "R6 valid with csb rise", spi_csb_n, 1);
        check(res_chan == eff, "R8 channel order", res_chan, eff);
        check(s_cmd == exp_cmd(eff) && !s_tail_bad, "R3 command byte", s_cmd, exp_cmd(eff));
        check(s_rise == exp_len, "R4 sck rises", s_rise, exp_len);
        check(res_data == exp_d, "R5 data", res_data, exp_d);
        check(!tbad, "R2 phase timing", tbad, 0);
        last_data = res_data;
        nframes++;
        exp_pos = (eff == 0) ? (inc_y ? 1 : (inc_t ? 2 : 0)) : (eff == 1) ? (inc_t ? 2 : 0) : 0;
      end
      if (res_valid && $past(res_valid)) check(0, "R6 pulse width", 2, 1);
    end
    sck_p = spi_sck; csb_p = spi_csb_n; mosi_p = spi_mosi;
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    while (!(spi_csb_n && cyc - last_rise > GAP + 2)) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_frame();
    int target = nframes + 1;
    int t = 0;
    while (nframes < target && t < 4000) begin @(negedge clk); t++; end
    check(nframes >= target, "R9 frame issued", nframes, target);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spi_csb_n === 1'b1 && spi_sck === 1'b0, "R1 reset csb/sck", spi_csb_n, 1);
    check(spi_mosi === 1'b0 && res_valid === 1'b0, "R1 reset mosi/valid", res_valid, 0);
    rst_n = 1'b1;
    last_rise = cyc;
    @(negedge clk);
    check(spi_csb_n && !spi_sck && !res_valid, "R1 after release", spi_csb_n, 1);
    // start inside the post-reset gap is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (GAP + 50) @(negedge clk);
    check(nframes == 0 && spi_csb_n, "R9 start in gap ignored", nframes, 0);
    // directed 975 on X
    force_en = 1'b1; force_val = 11'd975;
    pulse_start(); wait_frame();
    check(last_data == 11'd975, "R5 pattern 975", last_data, 975);
    // start during frame and during gap ignored
    force_val = 11'h7FF;
    pulse_start();
    repeat (HALF * 10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_frame();
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (GAP * 3) @(negedge clk);
    check(nframes == 2, "R9 extra starts ignored", nframes, 2);
    force_val = 11'h000;
    pulse_start(); wait_frame();
    check(last_data == 11'h000, "R5 all zeros", last_data, 0);
    force_en = 1'b0;
    // temperature directed
    inc_t = 1'b1; force_en = 1'b1; force_val = 11'h0A5;
    pulse_start(); wait_frame();
    pulse_start(); wait_frame();
    check(last_data == 11'h0A5, "R5 temp 8 bits", last_data, 165);
    force_en = 1'b0;
    // auto poll, full rotation, exact gap
    inc_y = 1'b1; inc_t = 1'b1; auto_poll = 1'b1;
    wait_frame();
    exact_gap = 1'b1;
    for (int i = 0; i < 8; i++) wait_frame();
    exact_gap = 1'b0; auto_poll = 1'b0;
    // random enables and data
    for (int i = 0; i < 30; i++) begin
      int m = int'($urandom % 4);
      inc_y = m[0]; inc_t = m[1];
      pulse_start(); wait_frame();
    end
    repeat (GAP) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial void'($urandom(32'd1234));

endmodule